// File: doc/BRIEF.md
# Strobed Host Bus Slave

This block lets an external host, running without a shared clock, read and write words inside the device over a narrow strobed bus. The host chooses the access with a 2-bit select field, a direction line and, in 16-bit mode, a half-word identifier. It then drives one of two data strobes low while chip select is low. All host lines are brought into the internal clock through two-flop synchronizers. Strobe edges are detected on the synchronized copies. An active-low ready output tells the host when it may end the access.

Internally there are three registers: a control word, a word address and a data holding register. Data reads go out over a request channel and come back over a response pulse. Data writes leave through a push channel towards a write buffer. Both channels are valid/ready. A request or push, once raised, stays up with stable contents until ready is seen in the same cycle. The response side is always accepted. It must arrive at least one cycle after its request handshake. When the write buffer reports no space, the block holds the host in the wait state. A parameter picks 32-bit or 16-bit host data. Another parameter chooses whether the selects are taken at the falling edge of an address strobe or at the falling edge of the access strobe.

Top module: `hostbus_slave`

## Requirements
- R1: After reset, ready is high (busy), the data output enable is low, and neither a fetch request nor a write push is raised.
- R2: The effective strobe is active only when chip select is low and exactly one of the two data strobes is low. Both strobes low, or chip select high, starts no access. Either data strobe alone may carry an access.
- R3: Select code 2 accesses the address register and code 0 the control register. Each holds what was written and returns it on a read. Codes 1 and 3 are data accesses.
- R4: A data read (the first half-word in 16-bit mode) raises a fetch request carrying the current address. Ready stays high until the response is loaded, and the loaded word is then presented on the data output.
- R5: With select code 1, the address advances by one after each completed data access, read or write. With code 3 it does not change.
- R6: On a data write, ready stays high while the write buffer reports no space. When the strobe later rises, one push carries the written word and the current address.
- R7: An access whose strobe rises before ready went low completes nothing: there is no push and no address change.
- R8: In 16-bit mode, half-word id 0 of a data read fetches and returns bits 15:0. Id 1 returns bits 31:16 of the loaded word with no new fetch. The address advances once, after id 1.
- R9: In 16-bit mode, a data write pushes nothing after half-word id 0. After id 1 it pushes one word, with the id-1 half in bits 31:16 and the id-0 half in bits 15:0.
- R10: In address-strobe mode, the selects are taken at the address strobe's falling edge. Later changes before the access strobe falls have no effect.
- R11: The data output enable rises only after the strobe falls on a read, stays low on writes, and drops once the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ds1_n | input | 1 | Host data strobe 1, active low |
| h_ds2_n | input | 1 | Host data strobe 2, active low |
| h_as_n | input | 1 | Host address strobe, active low (used when USE_AS=1) |
| h_ctl | input | 2 | Access select code (0 ctrl, 1 data+inc, 2 addr, 3 data) |
| h_rnw | input | 1 | 1 = read, 0 = write |
| h_half | input | 1 | Half-word id in 16-bit mode (0 low, 1 high) |
| h_din | input | DW | Host write data (low half only in 16-bit mode) |
| h_dout | output | DW | Host read data |
| h_doe | output | 1 | Enable for the host data driver |
| h_rdy_n | output | 1 | Ready to host, low = access may end |
| rq_valid | output | 1 | Fetch request valid |
| rq_ready | input | 1 | Fetch request accepted |
| rq_addr | output | AW | Fetch word address |
| rs_valid | input | 1 | Fetch response pulse |
| rs_data | input | DW | Fetch response word |
| wq_valid | output | 1 | Write push valid |
| wq_ready | input | 1 | Write buffer has space |
| wq_addr | output | AW | Write word address |
| wq_data | output | DW | Write word |

## Verification
Properties check four things on every cycle. Requests and pushes keep their contents until accepted. Ready stays busy while a fetch is pending. A push appears only right after a strobe rise, and the output enable comes up only right after a strobe fall. Ready may be low with the strobe inactive only in the cycle that ends the access. Directed scenarios cover the rest, because it depends on values carried across whole accesses: strobe decoding, register contents, fetch latency, address stepping, aborted writes, half-word assembly and select capture by the address strobe.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL     = 2'd0,
    SEL_DATA_INC = 2'd1,
    SEL_ADDR     = 2'd2,
    SEL_DATA_FIX = 2'd3
  } hsel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RWAIT,
    ST_WWAIT,
    ST_DONE
  } hstate_e;

  typedef struct packed {
    logic [1:0] ctl;
    logic       rnw;
    logic       half;
  } hsel_t;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hbs_strobe.sv
module hbs_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ds1_n,
  input  logic ds2_n,
  input  logic as_n,
  output logic act,
  output logic fall,
  output logic rise,
  output logic as_fall
);
  logic stb_n, prev_stb_n, prev_as_n;

  // inactive unless exactly one data strobe is low while selected
  assign stb_n = ~(ds1_n ^ ds2_n) | cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_stb_n <= 1'b1;
      prev_as_n  <= 1'b1;
    end else begin
      prev_stb_n <= stb_n;
      prev_as_n  <= as_n;
    end
  end

  assign act     = ~stb_n;
  assign fall    = prev_stb_n & ~stb_n;
  assign rise    = ~prev_stb_n & stb_n;
  assign as_fall = prev_as_n & ~as_n;
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int HALF_MODE = 0,
  parameter int USE_AS = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_cs_n,
  input  logic          h_ds1_n,
  input  logic          h_ds2_n,
  input  logic          h_as_n,
  input  logic [1:0]    h_ctl,
  input  logic          h_rnw,
  input  logic          h_half,
  input  logic [DW-1:0] h_din,
  output logic [DW-1:0] h_dout,
  output logic          h_doe,
  output logic          h_rdy_n,
  output logic          rq_valid,
  input  logic          rq_ready,
  output logic [AW-1:0] rq_addr,
  input  logic          rs_valid,
  input  logic [DW-1:0] rs_data,
  output logic          wq_valid,
  input  logic          wq_ready,
  output logic [AW-1:0] wq_addr,
  output logic [DW-1:0] wq_data
);
  import hbs_pkg::*;

  localparam int  HW = DW / 2;
  localparam int  IW = 8 + DW;
  localparam logic HM = (HALF_MODE != 0);
  localparam logic AM = (USE_AS != 0);

  logic [IW-1:0] s_vec;
  logic s_cs_n, s_ds1_n, s_ds2_n, s_as_n, s_rnw, s_half;
  logic [1:0] s_ctl;
  logic [DW-1:0] s_din;

  hbs_sync #(.W(IW), .STAGES(SYNC_STAGES), .RST({IW{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({h_cs_n, h_ds1_n, h_ds2_n, h_as_n, h_ctl, h_rnw, h_half, h_din}),
    .q(s_vec)
  );
  assign {s_cs_n, s_ds1_n, s_ds2_n, s_as_n, s_ctl, s_rnw, s_half, s_din} = s_vec;

  logic stb_act, stb_fall, stb_rise, as_fall;
  hbs_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .cs_n(s_cs_n), .ds1_n(s_ds1_n), .ds2_n(s_ds2_n),
    .as_n(s_as_n), .act(stb_act), .fall(stb_fall), .rise(stb_rise), .as_fall(as_fall)
  );

  hstate_e state;
  hsel_t live_sel, sel_as, cur_sel, sel_q;
  logic [DW-1:0] ctrl_q, dreg, addr_z, full_word;
  logic [AW-1:0] addr_q;
  logic [HW-1:0] wlo;
  logic abort_q, doe_q;
  logic cur_data, cur_first, commit_push;

  always_comb begin
    live_sel.ctl  = s_ctl;
    live_sel.rnw  = s_rnw;
    live_sel.half = HM & s_half;
    cur_sel       = AM ? sel_as : live_sel;
    cur_data      = cur_sel.ctl[0];
    cur_first     = ~cur_sel.half;
    commit_push   = sel_q.ctl[0] & (~HM | sel_q.half);
  end

  assign addr_z = DW'(addr_q);

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] nv,
                                          input logic hi);
    if (!HM) return nv;
    if (hi) return {nv[HW-1:0], old[HW-1:0]};
    return {old[DW-1:HW], nv[HW-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_as <= '0;
    else if (as_fall) sel_as <= live_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel_q    <= '0;
      ctrl_q   <= '0;
      addr_q   <= '0;
      dreg     <= '0;
      wlo      <= '0;
      abort_q  <= 1'b0;
      doe_q    <= 1'b0;
      rq_valid <= 1'b0;
      rq_addr  <= '0;
      wq_valid <= 1'b0;
      wq_addr  <= '0;
      wq_data  <= '0;
    end else begin
      if (wq_valid && wq_ready) wq_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (stb_fall) begin
          sel_q <= cur_sel;
          if (cur_sel.rnw) begin
            doe_q <= 1'b1;
            if (cur_data && cur_first) begin
              rq_valid <= 1'b1;
              rq_addr  <= addr_q;
              state    <= ST_REQ;
            end else begin
              state <= ST_DONE;
            end
          end else if (cur_data && (!HM || cur_sel.half)) begin
            state <= ST_WWAIT;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_REQ: begin
          if (stb_rise) begin abort_q <= 1'b1; doe_q <= 1'b0; end
          if (rq_ready) begin rq_valid <= 1'b0; state <= ST_RWAIT; end
        end
        ST_RWAIT: begin
          if (stb_rise) begin abort_q <= 1'b1; doe_q <= 1'b0; end
          if (rs_valid) begin
            dreg    <= rs_data;
            abort_q <= 1'b0;
            state   <= (abort_q || stb_rise) ? ST_IDLE : ST_DONE;
          end
        end
        ST_WWAIT: begin
          if (stb_rise) state <= ST_IDLE;
          else if (wq_ready && !wq_valid) state <= ST_DONE;
        end
        ST_DONE: if (stb_rise) begin
          state <= ST_IDLE;
          doe_q <= 1'b0;
          if (!sel_q.rnw) begin
            unique case (sel_q.ctl)
              SEL_CTRL: ctrl_q <= merge(ctrl_q, s_din, sel_q.half);
              SEL_ADDR: addr_q <= AW'(merge(addr_z, s_din, sel_q.half));
              default: if (commit_push) begin
                wq_valid <= 1'b1;
                wq_addr  <= addr_q;
                wq_data  <= HM ? {s_din[HW-1:0], wlo} : s_din;
              end else begin
                wlo <= s_din[HW-1:0];
              end
            endcase
          end
          if (sel_q.ctl == SEL_DATA_INC && (!HM || sel_q.half))
            addr_q <= addr_q + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (sel_q.ctl)
      SEL_CTRL: full_word = ctrl_q;
      SEL_ADDR: full_word = addr_z;
      default:  full_word = dreg;
    endcase
    if (HM) h_dout = {{HW{1'b0}}, sel_q.half ? full_word[DW-1:HW] : full_word[HW-1:0]};
    else    h_dout = full_word;
  end

  assign h_doe   = doe_q;
  assign h_rdy_n = (state != ST_DONE);
endmodule

// File: rtl/hbs_chk.sv
module hbs_chk #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_rdy_n,
  input logic          h_doe,
  input logic          rq_valid,
  input logic          rq_ready,
  input logic [AW-1:0] rq_addr,
  input logic          wq_valid,
  input logic          wq_ready,
  input logic [DW-1:0] wq_data,
  input logic          stb_act,
  input logic          stb_fall,
  input logic          stb_rise
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_addr)); // R4
  AST_BUSY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> h_rdy_n); // R4
  AST_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wq_valid && !wq_ready |=> wq_valid && $stable(wq_data)); // R6
  AST_PUSH_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wq_valid) |-> $past(stb_rise)); // R7
  AST_READY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rdy_n && !stb_act |-> stb_rise); // R7
  AST_DOE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_doe) |-> $past(stb_fall)); // R11
endmodule

bind hostbus_slave hbs_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_rdy_n(h_rdy_n), .h_doe(h_doe),
  .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
  .wq_valid(wq_valid), .wq_ready(wq_ready), .wq_data(wq_data),
  .stb_act(stb_act), .stb_fall(stb_fall), .stb_rise(stb_rise)
);

// File: tb/sim_hostbus_slave.sv
module sim_hostbus_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cs0 = 1, cs1 = 1, ds1 = 1, ds2 = 1, b_as = 1, b_rnw = 1, b_half = 0;
  logic [1:0] b_ctl = 2'd0;
  logic [31:0] b_din = '0;
  int rlat = 3;
  int nchk = 0, nfail = 0;

  logic [31:0] dout0, dout1, rsd0, rsd1, wqd0, wqd1, lwd0, lwd1;
  logic [15:0] rqa0, rqa1, wqa0, wqa1, lrq0, lrq1, lwa0, lwa1;
  logic doe0, doe1, rdy0, rdy1, rqv0, rqv1, rsv0, rsv1, wqv0, wqv1;
  logic wqr0 = 1, wqr1 = 1;
  logic rqr = 1;
  int cnt0, cnt1, nreq0, nreq1, npush0, npush1;
  logic busy0, busy1;

  hostbus_slave u0 (.clk(clk), .rst_n(rst_n), .h_cs_n(cs0), .h_ds1_n(ds1), .h_ds2_n(ds2),
    .h_as_n(b_as), .h_ctl(b_ctl), .h_rnw(b_rnw), .h_half(b_half), .h_din(b_din),
    .h_dout(dout0), .h_doe(doe0), .h_rdy_n(rdy0), .rq_valid(rqv0), .rq_ready(rqr),
    .rq_addr(rqa0), .rs_valid(rsv0), .rs_data(rsd0), .wq_valid(wqv0), .wq_ready(wqr0),
    .wq_addr(wqa0), .wq_data(wqd0));

  hostbus_slave #(.HALF_MODE(1), .USE_AS(1)) u1 (.clk(clk), .rst_n(rst_n), .h_cs_n(cs1),
    .h_ds1_n(ds1), .h_ds2_n(ds2), .h_as_n(b_as), .h_ctl(b_ctl), .h_rnw(b_rnw),
    .h_half(b_half), .h_din(b_din), .h_dout(dout1), .h_doe(doe1), .h_rdy_n(rdy1),
    .rq_valid(rqv1), .rq_ready(rqr), .rq_addr(rqa1), .rs_valid(rsv1), .rs_data(rsd1),
    .wq_valid(wqv1), .wq_ready(wqr1), .wq_addr(wqa1), .wq_data(wqd1));

  function automatic logic [31:0] fdat(input logic [15:0] a);
    return {~a, a};
  endfunction

  // internal-side models: fetch responder and write sink
  always @(posedge clk) begin
    rsv0 <= 1'b0; rsv1 <= 1'b0;
    if (!rst_n) begin
      busy0 <= 0; busy1 <= 0; cnt0 <= 0; cnt1 <= 0;
      nreq0 <= 0; nreq1 <= 0; npush0 <= 0; npush1 <= 0;
    end else begin
      if (rqv0 && rqr) begin busy0 <= 1; cnt0 <= rlat; nreq0 <= nreq0 + 1; lrq0 <= rqa0; end
      else if (busy0) begin
        if (cnt0 <= 1) begin busy0 <= 0; rsv0 <= 1; rsd0 <= fdat(lrq0); end
        else cnt0 <= cnt0 - 1;
      end
      if (rqv1 && rqr) begin busy1 <= 1; cnt1 <= rlat; nreq1 <= nreq1 + 1; lrq1 <= rqa1; end
      else if (busy1) begin
        if (cnt1 <= 1) begin busy1 <= 0; rsv1 <= 1; rsd1 <= fdat(lrq1); end
        else cnt1 <= cnt1 - 1;
      end
      if (wqv0 && wqr0) begin npush0 <= npush0 + 1; lwa0 <= wqa0; lwd0 <= wqd0; end
      if (wqv1 && wqr1) begin npush1 <= npush1 + 1; lwa1 <= wqa1; lwd1 <= wqd1; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic rdyof(input int d);
    return d != 0 ? rdy1 : rdy0;
  endfunction

  // one complete host access; chg flips the selects after the address strobe fell
  task automatic acc(input int d, input logic [1:0] c, input logic rw, input logic hf,
                     input logic [31:0] wd, input bit use2, input bit chg,
                     output logic [31:0] rd, output int cyc, output logic oe);
    @(negedge clk);
    b_ctl = c; b_rnw = rw; b_half = hf; b_din = wd;
    if (d == 1) b_as = 0;
    repeat (4) @(negedge clk);
    if (chg) begin b_ctl = ~c; b_rnw = ~rw; end
    repeat (2) @(negedge clk);
    if (d == 0) cs0 = 0; else cs1 = 0;
    if (use2) ds2 = 0; else ds1 = 0;
    cyc = 0;
    while (rdyof(d) && cyc < 400) begin @(negedge clk); cyc++; end
    rd = (d != 0) ? dout1 : dout0;
    oe = (d != 0) ? doe1 : doe0;
    ds1 = 1; ds2 = 1; cs0 = 1; cs1 = 1; b_as = 1;
    repeat (8) @(negedge clk);
  endtask

  logic [31:0] rv; int cy; logic oe;

  task automatic wr(input int d, input logic [1:0] c, input logic hf, input logic [31:0] v);
    acc(d, c, 1'b0, hf, v, 1'b0, 1'b0, rv, cy, oe);
  endtask

  task automatic t_reset();
    chk("R1 ready idle", rdy0, 1); chk("R1 doe idle", doe0, 0);
    chk("R1 no request", rqv0, 0); chk("R1 no push", wqv0, 0);
  endtask

  task automatic t_regs();
    wr(0, 2'd0, 0, 32'hDEADBEEF);
    chk("R11 doe low on write", oe, 0);
    acc(0, 2'd0, 1, 0, 0, 0, 0, rv, cy, oe);
    chk("R3 ctrl readback", rv, 32'hDEADBEEF);
    chk("R11 doe high on read", oe, 1);
    chk("R11 doe released", doe0, 0);
    wr(0, 2'd2, 0, 32'h00001234);
    acc(0, 2'd2, 1, 0, 0, 0, 0, rv, cy, oe);
    chk("R3 addr readback", rv, 32'h00001234);
  endtask

  task automatic t_decode();
    int seen;
    wr(0, 2'd2, 0, 32'h10);
    b_rnw = 1; b_ctl = 2'd2;
    @(negedge clk); cs0 = 0; ds1 = 0; ds2 = 0; seen = 0;
    repeat (30) begin @(negedge clk); if (!rdy0) seen++; end
    cs0 = 1; @(negedge clk); ds1 = 1; ds2 = 1;
    chk("R2 both strobes low ignored", seen, 0);
    @(negedge clk); ds1 = 0; seen = 0;
    repeat (30) begin @(negedge clk); if (!rdy0) seen++; end
    ds1 = 1; repeat (4) @(negedge clk);
    chk("R2 chip select high ignored", seen, 0);
    acc(0, 2'd2, 1, 0, 0, 1, 0, rv, cy, oe);
    chk("R2 second strobe access", rv, 32'h10);
  endtask

  task automatic t_fetch();
    int n;
    wr(0, 2'd2, 0, 32'h40);
    n = nreq0; rlat = 20;
    acc(0, 2'd3, 1, 0, 0, 0, 0, rv, cy, oe);
    rlat = 3;
    chk("R4 fetched word", rv, fdat(16'h40));
    chk("R4 request address", lrq0, 32'h40);
    chk("R4 one request", nreq0 - n, 1);
    chk("R4 ready held during fetch", cy >= 20, 1);
  endtask

  task automatic t_inc();
    wr(0, 2'd2, 0, 32'h100);
    acc(0, 2'd1, 1, 0, 0, 0, 0, rv, cy, oe); chk("R5 inc read first", rv, fdat(16'h100));
    acc(0, 2'd1, 1, 0, 0, 0, 0, rv, cy, oe); chk("R5 inc read second", rv, fdat(16'h101));
    acc(0, 2'd3, 1, 0, 0, 0, 0, rv, cy, oe); chk("R5 fixed read", rv, fdat(16'h102));
    acc(0, 2'd2, 1, 0, 0, 0, 0, rv, cy, oe); chk("R5 fixed no step", rv, 32'h102);
    wr(0, 2'd1, 0, 32'h55);
    chk("R5 inc write address", lwa0, 32'h102);
    acc(0, 2'd2, 1, 0, 0, 0, 0, rv, cy, oe); chk("R5 write stepped", rv, 32'h103);
  endtask

  task automatic t_full();
    int n, seen;
    n = npush0; wqr0 = 0;
    @(negedge clk); b_ctl = 2'd3; b_rnw = 0; b_din = 32'hCAFEF00D;
    repeat (2) @(negedge clk); cs0 = 0; ds1 = 0; seen = 0;
    repeat (30) begin @(negedge clk); if (!rdy0) seen++; end
    chk("R6 ready held while full", seen, 0);
    wqr0 = 1;
    repeat (10) begin @(negedge clk); if (!rdy0) seen++; end
    chk("R6 ready after space", seen > 0, 1);
    ds1 = 1; cs0 = 1; repeat (8) @(negedge clk);
    chk("R6 one push", npush0 - n, 1);
    chk("R6 push data", lwd0, 32'hCAFEF00D);
    chk("R6 push address", lwa0, 32'h103);
  endtask

  task automatic t_abort();
    int n;
    wr(0, 2'd2, 0, 32'h200);
    n = npush0; wqr0 = 0;
    @(negedge clk); b_ctl = 2'd1; b_rnw = 0; b_din = 32'h0BADF00D;
    repeat (2) @(negedge clk); cs0 = 0; ds1 = 0;
    repeat (15) @(negedge clk);
    ds1 = 1; cs0 = 1;
    repeat (10) @(negedge clk); wqr0 = 1;
    repeat (20) @(negedge clk);
    chk("R7 aborted write not pushed", npush0 - n, 0);
    chk("R7 ready stays busy", rdy0, 1);
    acc(0, 2'd2, 1, 0, 0, 0, 0, rv, cy, oe);
    chk("R7 no address step", rv, 32'h200);
  endtask

  task automatic t_half_rd();
    int n;
    wr(1, 2'd2, 0, 32'h0300);
    wr(1, 2'd2, 1, 32'h0000);
    n = nreq1;
    acc(1, 2'd1, 1, 0, 0, 0, 0, rv, cy, oe); chk("R8 low half", rv, 32'h0300);
    chk("R8 first half fetches", nreq1 - n, 1);
    acc(1, 2'd1, 1, 1, 0, 0, 0, rv, cy, oe); chk("R8 high half", rv, 32'hFCFF);
    chk("R8 no second fetch", nreq1 - n, 1);
    acc(1, 2'd2, 1, 0, 0, 0, 0, rv, cy, oe); chk("R8 single step", rv, 32'h0301);
  endtask

  task automatic t_half_wr();
    int n;
    n = npush1;
    wr(1, 2'd3, 0, 32'h1111);
    chk("R9 no push after first half", npush1 - n, 0);
    wr(1, 2'd3, 1, 32'h2222);
    chk("R9 push after second half", npush1 - n, 1);
    chk("R9 assembled word", lwd1, 32'h22221111);
    chk("R9 push address", lwa1, 32'h0301);
  endtask

  task automatic t_as();
    acc(1, 2'd2, 1, 0, 32'h0000FFFF, 0, 1, rv, cy, oe);
    chk("R10 selects from address strobe", rv, 32'h0301);
    chk("R10 direction from address strobe", oe, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_regs();
    t_decode();
    t_fetch();
    t_inc();
    t_full();
    t_abort();
    t_half_rd();
    t_half_wr();
    t_as();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule